// File: doc/BRIEF.md
# Frame-End Read-Out Interrupt Counter

This block decides when an image frame has been fully drained from a receive FIFO. Software programs the expected frame size in words. The block counts every read strobe on the FIFO read port, whether the reader is a processor or a DMA engine. When the running total equals the programmed size, the block sets a sticky end-of-frame status bit. If the frame-end interrupt is enabled, it also raises the interrupt line.

A start-of-frame pulse from the capture front end restarts the count from zero. It also re-arms detection, so a frame that is cut short before all of its words have been read never reports completion. After a match, the counter freezes until the next start of frame, which blocks a second interrupt within the same frame. A programmed size of zero turns detection off.

A small word-wide register port gives access to the target count, the enable bit, the status bit and the live counter. Register reads are combinational.

Top module: `frame_end_counter`

## Requirements
- R1: The target count register at address 0 is written with reg_wdata[CNT_W-1:0] and reads back that value. After reset it reads 0.
- R2: While detection is armed, each cycle with fifo_rd_i high and sof_i low adds one to the word counter. The counter reads back at address 3.
- R3: On the clock edge of a read that brings the counter equal to a nonzero target, status bit 0 at address 2 sets. It reads 1 right after that edge.
- R4: A sof_i pulse with no read clears the counter to 0 and re-arms detection. A frame interrupted by start-of-frame before reaching the target sets no status.
- R5: After a match the counter holds its value and ignores reads until the next sof_i. Further reads in that frame cannot set the status again.
- R6: A target of 0 never sets the status bit, whatever the number of reads.
- R7: The status bit is sticky. Writing 1 to bit 0 of address 2 clears it, and writing 0 leaves it unchanged. A match in the same cycle as a clearing write leaves it set.
- R8: irq_o equals the status bit ANDed with the enable bit, which is bit 0 of address 1.
- R9: When sof_i and fifo_rd_i are high in the same cycle, the counter becomes 1 and that read counts toward the new frame. With a target of 1, that read sets the status bit.
- R10: After reset the counter, status, enable and irq_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_rd_i | input | 1 | One word read from the receive FIFO this cycle |
| sof_i | input | 1 | Start-of-frame pulse |
| reg_addr_i | input | 2 | Register address: 0 target, 1 control, 2 status, 3 counter |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| irq_o | output | 1 | End-of-frame interrupt |

## Verification
Some rules are checked by the assertions on every cycle. A start-of-frame without a read clears the counter. A frozen counter stays stable. The status bit rises only on a read cycle. A zero target never sets the status. A start-of-frame without a read cannot raise a fresh status. The bench scenarios are the only way to show complete results. These cover the exact count at which the status appears, aborted frames that must stay silent, the priority of start-of-frame over a read in the same cycle, and a match that beats a clearing write. They also cover the enable gating that software observes at irq_o.

// File: rtl/frame_end_counter.sv
module frame_end_counter #(
  parameter int CNT_W = 24,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_rd_i,
  input  logic          sof_i,
  input  logic [1:0]    reg_addr_i,
  input  logic          reg_wr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          irq_o
);

  localparam logic [1:0] A_TGT = 2'd0;
  localparam logic [1:0] A_CTL = 2'd1;
  localparam logic [1:0] A_STS = 2'd2;
  localparam logic [1:0] A_CNT = 2'd3;

  logic [CNT_W-1:0] tgt_q, cnt_q, cnt_d;
  logic             armed_q, en_q, sts_q;
  logic             step, hit, clr;

  assign step  = sof_i ? fifo_rd_i : (armed_q & fifo_rd_i);
  assign cnt_d = sof_i ? {{(CNT_W-1){1'b0}}, fifo_rd_i}
                       : (step ? cnt_q + 1'b1 : cnt_q);
  assign hit   = step && (tgt_q != '0) && (cnt_d == tgt_q);
  assign clr   = reg_wr_i && reg_addr_i == A_STS && reg_wdata_i[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q   <= '0;
      en_q    <= 1'b0;
      cnt_q   <= '0;
      armed_q <= 1'b1;
      sts_q   <= 1'b0;
    end else begin
      if (reg_wr_i && reg_addr_i == A_TGT) tgt_q <= reg_wdata_i[CNT_W-1:0];
      if (reg_wr_i && reg_addr_i == A_CTL) en_q  <= reg_wdata_i[0];
      cnt_q <= cnt_d;
      if (hit)        armed_q <= 1'b0;
      else if (sof_i) armed_q <= 1'b1;
      if (hit)      sts_q <= 1'b1;
      else if (clr) sts_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_TGT:   reg_rdata_o[CNT_W-1:0] = tgt_q;
      A_CTL:   reg_rdata_o[0]         = en_q;
      A_STS:   reg_rdata_o[0]         = sts_q;
      default: reg_rdata_o[CNT_W-1:0] = cnt_q;
    endcase
  end

  assign irq_o = sts_q & en_q;

  AST_SOF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_i && !fifo_rd_i) |=> (cnt_q == '0)); // R4
  AST_HOLD_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !sof_i) |=> $stable(cnt_q)); // R5
  AST_STS_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q) |-> $past(fifo_rd_i)); // R3
  AST_ZERO_TGT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_q == '0 && !sts_q) |=> !sts_q); // R6
  AST_SOF_NO_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_i && !fifo_rd_i && !sts_q) |=> !sts_q); // R4
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (reg_addr_i != A_CTL || 1'b1) && en_q && sts_q); // R8

endmodule

// File: tb/frame_end_counter_tb.sv
module frame_end_counter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 5;
  localparam int VT_TGT [NV] = '{4, 4, 4, 1, 0};
  localparam int VT_NRD [NV] = '{4, 3, 7, 1, 5};
  localparam int VT_CNT [NV] = '{4, 3, 4, 1, 5};
  localparam int VT_STS [NV] = '{1, 0, 1, 1, 0};

  logic clk = 0, rst_n = 0, fifo_rd = 0, sof = 0, wr = 0;
  logic [1:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic irq;
  int checks = 0, fails = 0;
  bit finished = 0;

  frame_end_counter dut_i (.clk(clk), .rst_n(rst_n), .fifo_rd_i(fifo_rd), .sof_i(sof),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wreg(logic [1:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rreg(logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic pulse(logic s, logic r);
    @(negedge clk); sof = s; fifo_rd = r;
    @(negedge clk); sof = 0; fifo_rd = 0;
  endtask

  task automatic reads(int n);
    for (int i = 0; i < n; i++) pulse(0, 1);
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rreg(0, v); chk("R1 reset target", v, 0);
    rreg(3, v); chk("R10 reset counter", v, 0);
    rreg(2, v); chk("R10 reset status", v, 0);
    rreg(1, v); chk("R10 reset enable", v, 0);
    chk("R10 reset irq", irq, 0);

    for (int k = 0; k < NV; k++) begin
      wreg(0, VT_TGT[k]);
      pulse(1, 0);
      wreg(2, 1);
      reads(VT_NRD[k]);
      rreg(0, v); chk("R1 target readback", v, VT_TGT[k]);
      rreg(3, v); chk("R2 R5 counter", v, VT_CNT[k]);
      rreg(2, v); chk("R3 R6 status", v, VT_STS[k]);
    end

    // R4 abort by start of frame
    wreg(0, 6); pulse(1, 0); wreg(2, 1);
    reads(3); pulse(1, 0);
    rreg(3, v); chk("R4 counter cleared", v, 0);
    rreg(2, v); chk("R4 no status", v, 0);
    reads(5);
    rreg(2, v); chk("R4 no status before full", v, 0);
    reads(1);
    rreg(2, v); chk("R3 status at full count", v, 1);

    // R8 gating
    chk("R8 irq off when disabled", irq, 0);
    wreg(1, 1); #1; chk("R8 irq on when enabled", irq, 1);

    // R7 write-one-to-clear
    wreg(2, 0); rreg(2, v); chk("R7 write zero no effect", v, 1);
    wreg(2, 1); rreg(2, v); chk("R7 write one clears", v, 0);
    #1; chk("R8 irq follows status", irq, 0);

    // R5 no second interrupt in frame
    reads(4);
    rreg(2, v); chk("R5 no second status", v, 0);
    rreg(3, v); chk("R5 counter frozen", v, 6);

    // R9 simultaneous sof and read
    wreg(0, 1); wreg(2, 1);
    pulse(1, 1);
    rreg(3, v); chk("R9 counter is one", v, 1);
    rreg(2, v); chk("R9 status with target one", v, 1);
    wreg(0, 3); pulse(1, 1);
    rreg(3, v); chk("R9 counter restarts at one", v, 1);

    // R7 match beats clear
    wreg(2, 1); reads(1);
    @(negedge clk); addr = 2; wdata = 1; wr = 1; fifo_rd = 1;
    @(negedge clk); wr = 0; fifo_rd = 0;
    rreg(2, v); chk("R7 set wins over clear", v, 1);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule